// File: doc/BRIEF.md
# Predictive Texel Quad Buffer

This block sits between a bilinear texture filter and the first-level texture cache. The filter presents the integer coordinate of the upper-left texel of its 2x2 footprint. The block returns the four 32-bit texels of that footprint in a single response beat. It keeps up to four complete 4x4 texel tiles in registers, so neighbouring pixels that land on the same tiles are served without touching the cache.

The position of the first texel inside its tile tells the block how many tiles the footprint covers. If the column is not the last in the tile and the row is not the last, one tile holds all four texels. If only the column is the last, two tiles side by side are needed. If only the row is the last, two tiles stacked vertically are needed. If both are the last, four tiles are needed. The block compares tags only for the tiles it actually needs. Each absent tile is requested from the cache as one 512-bit transfer, and the request stalls until that fill arrives. A running count of tag compares is exposed so that the saving can be measured.

Top module: `texquad_buf`

## Requirements
- R1: After reset no tile is resident, `req_ready` is 1, `rsp_valid` and `fill_req_valid` are 0, and `cmp_count` is 0.
- R2: `rsp_texels[32*j +: 32]` carries the texel at (x + j%2, y + j/2) for j = 0..3, where (x, y) is the accepted request coordinate.
- R3: A request whose x[1:0] and y[1:0] are both different from 3 performs one tag compare. One with only x[1:0]==3 performs two compares, on tiles (x>>2, y>>2) and (x>>2 + 1, y>>2). One with only y[1:0]==3 performs two compares, on tiles (x>>2, y>>2) and (x>>2, y>>2 + 1). One with both equal to 3 performs four compares.
- R4: On a miss, `fill_req_valid` rises with `fill_req_tx`/`fill_req_ty` holding the tile coordinate, and both stay stable until `fill_valid`. Word `fill_data[32*o +: 32]` is the texel at in-tile offset o = {row[1:0], column[1:0]}.
- R5: A request whose tiles are all resident issues no fill, and `rsp_valid` is high in the cycle N+1 after acceptance, where N is the number of tiles touched.
- R6: `req_ready` is low from the cycle after acceptance until the response. `rsp_valid` is high for exactly one cycle, and `req_ready` returns to 1 in the following cycle.
- R7: Missing tiles are filled in the order tile (0,0), (+1,0), (0,+1), (+1,+1) of the footprint. Each fill goes to the first buffer, counting round-robin from the one after the last buffer filled, that holds no tile already taken for the current request.
- R8: `cmp_count` rises by one per tile lookup. It does not change while idle or while a fill is outstanding.
- R9: A `fill_valid` pulse while no fill is outstanding changes no resident tile and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Footprint request valid |
| req_ready | output | 1 | Block can accept a request |
| req_x | input | COORD_W | Column of the first texel |
| req_y | input | COORD_W | Row of the first texel |
| rsp_valid | output | 1 | Texel quad valid, one cycle |
| rsp_texels | output | 128 | Four texels, index j at bits 32*j |
| fill_req_valid | output | 1 | Tile fill wanted from the cache |
| fill_req_tx | output | COORD_W-2 | Tile column of the fill |
| fill_req_ty | output | COORD_W-2 | Tile row of the fill |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | 512 | Sixteen texels of the tile |
| cmp_count | output | CNT_W | Tag compares performed |

## Verification
A tile tag or valid bit that goes wrong shows up at the next request touching that tile. The symptom is either a fill request the reference did not expect, or a missing one, and it appears within one or two cycles of acceptance. A wrong victim choice is seen as a wrong eviction one or more requests later, which is why long streams that revisit a small set of tiles are run. A wrong buffer-slot mapping or in-tile offset appears as corrupted texel data on the very response beat. A miscounted compare shows in `cmp_count` on that same beat.

// File: rtl/texquad_pkg.sv
package texquad_pkg;
  localparam int TEXEL_W     = 32;
  localparam int TILE_TEXELS = 16;
  localparam int FILL_W      = TEXEL_W * TILE_TEXELS;
  localparam int QUAD        = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL, ST_RESP} tq_state_e;
  typedef enum logic [1:0] {SPAN_ONE, SPAN_H, SPAN_V, SPAN_FOUR} tq_span_e;

  // Maps the k-th lookup of a request onto a footprint slot
  // (slot 0 = base tile, 1 = right, 2 = below, 3 = diagonal).
  function automatic logic [1:0] slot_of(tq_span_e sp, logic [1:0] k);
    case (sp)
      SPAN_ONE: return 2'd0;
      SPAN_H:   return k[0] ? 2'd1 : 2'd0;
      SPAN_V:   return k[0] ? 2'd2 : 2'd0;
      default:  return k;
    endcase
  endfunction
endpackage

// File: rtl/texquad_span.sv
module texquad_span import texquad_pkg::*; #(
  parameter int COORD_W = 12,
  localparam int TILE_W = COORD_W - 2
) (
  input  logic [COORD_W-1:0]         x_i,
  input  logic [COORD_W-1:0]         y_i,
  output tq_span_e                   span_o,
  output logic [2:0]                 n_tiles_o,
  output logic [3:0][TILE_W-1:0]     slot_tx_o,
  output logic [3:0][TILE_W-1:0]     slot_ty_o,
  output logic [QUAD-1:0][3:0]       off_o,
  output logic [QUAD-1:0][1:0]       tsel_o
);
  logic              edge_x, edge_y;
  logic [TILE_W-1:0] bx, by;

  assign edge_x = &x_i[1:0];
  assign edge_y = &y_i[1:0];
  assign bx     = x_i[COORD_W-1:2];
  assign by     = y_i[COORD_W-1:2];

  always_comb begin
    case ({edge_y, edge_x})
      2'b00:   begin span_o = SPAN_ONE;  n_tiles_o = 3'd1; end
      2'b01:   begin span_o = SPAN_H;    n_tiles_o = 3'd2; end
      2'b10:   begin span_o = SPAN_V;    n_tiles_o = 3'd2; end
      default: begin span_o = SPAN_FOUR; n_tiles_o = 3'd4; end
    endcase
  end

  assign slot_tx_o[0] = bx;
  assign slot_tx_o[1] = bx + 1'b1;
  assign slot_tx_o[2] = bx;
  assign slot_tx_o[3] = bx + 1'b1;
  assign slot_ty_o[0] = by;
  assign slot_ty_o[1] = by;
  assign slot_ty_o[2] = by + 1'b1;
  assign slot_ty_o[3] = by + 1'b1;

  // Per-texel in-tile offset and the footprint slot holding it
  for (genvar j = 0; j < QUAD; j++) begin : g_texel
    logic [1:0] col, row;
    assign col       = x_i[1:0] + 2'(j % 2);
    assign row       = y_i[1:0] + 2'(j / 2);
    assign off_o[j]  = {row, col};
    assign tsel_o[j] = {edge_y & 1'(j / 2), edge_x & 1'(j % 2)};
  end
endmodule

// File: rtl/texquad_store.sv
module texquad_store import texquad_pkg::*; #(
  parameter int TILE_W  = 10,
  parameter int NUM_BUF = 4,
  localparam int BIDX_W = $clog2(NUM_BUF)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TILE_W-1:0]             look_tx,
  input  logic [TILE_W-1:0]             look_ty,
  output logic                          hit,
  output logic [BIDX_W-1:0]             hit_idx,
  input  logic                          wr_en,
  input  logic [BIDX_W-1:0]             wr_idx,
  input  logic [TILE_W-1:0]             wr_tx,
  input  logic [TILE_W-1:0]             wr_ty,
  input  logic [FILL_W-1:0]             wr_data,
  input  logic [QUAD-1:0][BIDX_W-1:0]   rd_buf,
  input  logic [QUAD-1:0][3:0]          rd_off,
  output logic [QUAD-1:0][TEXEL_W-1:0]  rd_texel
);
  logic [NUM_BUF-1:0] vld_q, vld_d;
  logic [NUM_BUF-1:0] hit_vec;
  logic [NUM_BUF-1:0] buf_we;
  logic [TILE_W-1:0]  tagx_q [NUM_BUF];
  logic [TILE_W-1:0]  tagy_q [NUM_BUF];
  logic [FILL_W-1:0]  data_q [NUM_BUF];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    assign buf_we[i]  = wr_en && (int'(wr_idx) == i);
    assign hit_vec[i] = vld_q[i] && (tagx_q[i] == look_tx) && (tagy_q[i] == look_ty);

    always_ff @(posedge clk) begin
      if (buf_we[i]) begin
        tagx_q[i] <= wr_tx;
        tagy_q[i] <= wr_ty;
        data_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    hit     = |hit_vec;
    hit_idx = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (hit_vec[i]) hit_idx = BIDX_W'(i);
  end

  for (genvar j = 0; j < QUAD; j++) begin : g_rd
    assign rd_texel[j] = data_q[rd_buf[j]][int'(rd_off[j]) * TEXEL_W +: TEXEL_W];
  end

  // A tile is never held twice
  p_tag_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // A fill is only written for a tile found absent
  p_fill_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !hit);
endmodule

// File: rtl/texquad_ctrl.sv
module texquad_ctrl import texquad_pkg::*; #(
  parameter int COORD_W = 12,
  parameter int NUM_BUF = 4,
  parameter int CNT_W   = 16,
  localparam int TILE_W = COORD_W - 2,
  localparam int BIDX_W = $clog2(NUM_BUF)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [COORD_W-1:0]           req_x,
  input  logic [COORD_W-1:0]           req_y,
  output logic [COORD_W-1:0]           cur_x,
  output logic [COORD_W-1:0]           cur_y,
  input  tq_span_e                     span,
  input  logic [2:0]                   n_tiles,
  input  logic [3:0][TILE_W-1:0]       slot_tx,
  input  logic [3:0][TILE_W-1:0]       slot_ty,
  input  logic                         hit,
  input  logic [BIDX_W-1:0]            hit_idx,
  output logic [TILE_W-1:0]            look_tx,
  output logic [TILE_W-1:0]            look_ty,
  output logic                         fill_req_valid,
  input  logic                         fill_valid,
  output logic                         wr_en,
  output logic [BIDX_W-1:0]            wr_idx,
  output logic [3:0][BIDX_W-1:0]       slot_buf,
  output logic                         rsp_valid,
  output logic [CNT_W-1:0]             cmp_count
);
  tq_state_e               state_q, state_d;
  logic [COORD_W-1:0]      x_q, x_d, y_q, y_d;
  logic [1:0]              k_q, k_d;
  logic [3:0][BIDX_W-1:0]  sbuf_q, sbuf_d;
  logic [NUM_BUF-1:0]      lock_q, lock_d;
  logic [BIDX_W-1:0]       rr_q, rr_d, vic_q, vic_d, vic_c;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [1:0]              cur_slot;
  logic                    last_k;
  logic                    found;

  assign cur_slot = slot_of(span, k_q);
  assign look_tx  = slot_tx[cur_slot];
  assign look_ty  = slot_ty[cur_slot];
  assign last_k   = ({1'b0, k_q} + 3'd1) == n_tiles;

  // Round-robin victim, skipping buffers already bound to this request
  always_comb begin
    vic_c = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      int cand;
      cand = (int'(rr_q) + i) % NUM_BUF;
      if (!found && !lock_q[cand]) begin
        vic_c = BIDX_W'(cand);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    x_d     = x_q;
    y_d     = y_q;
    k_d     = k_q;
    sbuf_d  = sbuf_q;
    lock_d  = lock_q;
    rr_d    = rr_q;
    vic_d   = vic_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        x_d     = req_x;
        y_d     = req_y;
        k_d     = 2'd0;
        lock_d  = '0;
        state_d = ST_LOOK;
      end
      ST_LOOK: begin
        cnt_d = cnt_q + 1'b1;
        if (hit) begin
          sbuf_d[cur_slot] = hit_idx;
          lock_d[hit_idx]  = 1'b1;
          if (last_k) state_d = ST_RESP;
          else        k_d     = k_q + 1'b1;
        end else begin
          vic_d   = vic_c;
          state_d = ST_FILL;
        end
      end
      ST_FILL: if (fill_valid) begin
        wr_en            = 1'b1;
        sbuf_d[cur_slot] = vic_q;
        lock_d[vic_q]    = 1'b1;
        rr_d             = (int'(vic_q) == NUM_BUF - 1) ? '0 : vic_q + 1'b1;
        if (last_k) state_d = ST_RESP;
        else begin
          k_d     = k_q + 1'b1;
          state_d = ST_LOOK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      k_q     <= '0;
      sbuf_q  <= '0;
      lock_q  <= '0;
      rr_q    <= '0;
      vic_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      y_q     <= y_d;
      k_q     <= k_d;
      sbuf_q  <= sbuf_d;
      lock_q  <= lock_d;
      rr_q    <= rr_d;
      vic_q   <= vic_d;
      cnt_q   <= cnt_d;
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign rsp_valid      = (state_q == ST_RESP);
  assign fill_req_valid = (state_q == ST_FILL);
  assign cur_x          = x_q;
  assign cur_y          = y_q;
  assign wr_idx         = vic_q;
  assign slot_buf       = sbuf_q;
  assign cmp_count      = cnt_q;

  p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_valid) |=> fill_req_valid && $stable(look_tx) && $stable(look_ty));
  p_idle_no_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> $stable(cmp_count));
  p_fill_no_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |=> $stable(cmp_count));
  p_victim_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !lock_q[wr_idx]);
endmodule

// File: rtl/texquad_buf.sv
module texquad_buf import texquad_pkg::*; #(
  parameter int COORD_W = 12,
  parameter int NUM_BUF = 4,
  parameter int CNT_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [COORD_W-1:0]        req_x,
  input  logic [COORD_W-1:0]        req_y,
  output logic                      rsp_valid,
  output logic [QUAD*TEXEL_W-1:0]   rsp_texels,
  output logic                      fill_req_valid,
  output logic [COORD_W-3:0]        fill_req_tx,
  output logic [COORD_W-3:0]        fill_req_ty,
  input  logic                      fill_valid,
  input  logic [FILL_W-1:0]         fill_data,
  output logic [CNT_W-1:0]          cmp_count
);
  localparam int TILE_W = COORD_W - 2;
  localparam int BIDX_W = $clog2(NUM_BUF);

  logic [COORD_W-1:0]            cur_x, cur_y;
  tq_span_e                      span;
  logic [2:0]                    n_tiles;
  logic [3:0][TILE_W-1:0]        slot_tx, slot_ty;
  logic [QUAD-1:0][3:0]          off;
  logic [QUAD-1:0][1:0]          tsel;
  logic                          hit;
  logic [BIDX_W-1:0]             hit_idx;
  logic [TILE_W-1:0]             look_tx, look_ty;
  logic                          wr_en;
  logic [BIDX_W-1:0]             wr_idx;
  logic [3:0][BIDX_W-1:0]        slot_buf;
  logic [QUAD-1:0][BIDX_W-1:0]   rd_buf;
  logic [QUAD-1:0][TEXEL_W-1:0]  rd_texel;

  texquad_span #(.COORD_W(COORD_W)) u_span (
    .x_i(cur_x), .y_i(cur_y), .span_o(span), .n_tiles_o(n_tiles),
    .slot_tx_o(slot_tx), .slot_ty_o(slot_ty), .off_o(off), .tsel_o(tsel)
  );

  texquad_ctrl #(.COORD_W(COORD_W), .NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .cur_x(cur_x), .cur_y(cur_y),
    .span(span), .n_tiles(n_tiles), .slot_tx(slot_tx), .slot_ty(slot_ty),
    .hit(hit), .hit_idx(hit_idx), .look_tx(look_tx), .look_ty(look_ty),
    .fill_req_valid(fill_req_valid), .fill_valid(fill_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .slot_buf(slot_buf),
    .rsp_valid(rsp_valid), .cmp_count(cmp_count)
  );

  for (genvar j = 0; j < QUAD; j++) begin : g_out
    assign rd_buf[j] = slot_buf[tsel[j]];
    assign rsp_texels[j*TEXEL_W +: TEXEL_W] = rd_texel[j];
  end

  texquad_store #(.TILE_W(TILE_W), .NUM_BUF(NUM_BUF)) u_store (
    .clk(clk), .rst_n(rst_n), .look_tx(look_tx), .look_ty(look_ty),
    .hit(hit), .hit_idx(hit_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tx(look_tx), .wr_ty(look_ty), .wr_data(fill_data),
    .rd_buf(rd_buf), .rd_off(off), .rd_texel(rd_texel)
  );

  assign fill_req_tx = look_tx;
  assign fill_req_ty = look_ty;
endmodule

// File: tb/texquad_buf_bench.sv
module texquad_buf_bench;
  localparam int COORD_W = 12;
  localparam int TILE_W  = COORD_W - 2;
  localparam int CNT_W   = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [COORD_W-1:0]   req_x = '0, req_y = '0;
  logic                 rsp_valid;
  logic [127:0]         rsp_texels;
  logic                 fill_req_valid;
  logic [TILE_W-1:0]    fill_req_tx, fill_req_ty;
  logic                 fill_valid = 1'b0;
  logic [511:0]         fill_data = '0;
  logic [CNT_W-1:0]     cmp_count;

  always #4 clk = ~clk;

  texquad_buf #(.COORD_W(COORD_W), .NUM_BUF(4), .CNT_W(CNT_W)) u_texquad_buf (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .rsp_valid(rsp_valid), .rsp_texels(rsp_texels),
    .fill_req_valid(fill_req_valid), .fill_req_tx(fill_req_tx), .fill_req_ty(fill_req_ty),
    .fill_valid(fill_valid), .fill_data(fill_data), .cmp_count(cmp_count)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // Reference state: resident tiles, round-robin pointer, pending fills
  int m_vld[4], m_tx[4], m_ty[4];
  int m_rr = 0;
  int exp_fx[$], exp_fy[$];
  longint exp_cmp = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] tex(input int x, input int y);
    return {4'hA, 12'(x), 4'h5, 12'(y)};
  endfunction

  function automatic logic [511:0] tile_data(input int tx, input int ty);
    logic [511:0] d;
    for (int o = 0; o < 16; o++) d[o*32 +: 32] = tex(tx*4 + o%4, ty*4 + o/4);
    return d;
  endfunction

  task automatic model_req(input int x, input int y, output int ntile);
    int sx[$], sy[$];
    bit locked[4];
    sx.push_back(x/4); sy.push_back(y/4);
    if (x%4 == 3) begin sx.push_back(x/4 + 1); sy.push_back(y/4); end
    if (y%4 == 3) begin sx.push_back(x/4); sy.push_back(y/4 + 1); end
    if (x%4 == 3 && y%4 == 3) begin sx.push_back(x/4 + 1); sy.push_back(y/4 + 1); end
    for (int b = 0; b < 4; b++) locked[b] = 0;
    for (int s = 0; s < sx.size(); s++) begin
      int found = -1;
      for (int b = 0; b < 4; b++)
        if (m_vld[b] != 0 && m_tx[b] == sx[s] && m_ty[b] == sy[s]) found = b;
      if (found >= 0) locked[found] = 1;
      else begin
        int v = -1;
        for (int i = 0; i < 4; i++)
          if (v < 0 && !locked[(m_rr + i) % 4]) v = (m_rr + i) % 4;
        exp_fx.push_back(sx[s]); exp_fy.push_back(sy[s]);
        m_vld[v] = 1; m_tx[v] = sx[s]; m_ty[v] = sy[s];
        locked[v] = 1; m_rr = (v + 1) % 4;
      end
    end
    ntile = sx.size();
    exp_cmp += ntile;
  endtask

  task automatic do_req(input int x, input int y, input int dly);
    int ntile, misses, cyc, fcnt;
    @(negedge clk);
    model_req(x, y, ntile);
    misses = exp_fx.size();
    check(req_ready == 1'b1, "R6 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_x = COORD_W'(x); req_y = COORD_W'(y);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; fcnt = -1;
    while (1) begin
      fill_valid = 1'b0;
      if (rsp_valid || cyc > 100) break;
      check(req_ready == 1'b0, "R6 busy not ready", req_ready, 0);
      if (fill_req_valid) begin
        if (fcnt < 0) begin
          if (exp_fx.size() == 0)
            check(0, "R7 unexpected fill", {fill_req_tx, fill_req_ty}, 0);
          else
            check(fill_req_tx == TILE_W'(exp_fx[0]) && fill_req_ty == TILE_W'(exp_fy[0]),
                  "R4 fill tile", {fill_req_tx, fill_req_ty},
                  {TILE_W'(exp_fx[0]), TILE_W'(exp_fy[0])});
          fcnt = dly;
        end
        if (fcnt == 0) begin
          fill_valid = 1'b1;
          fill_data  = tile_data(int'(fill_req_tx), int'(fill_req_ty));
          if (exp_fx.size() != 0) begin void'(exp_fx.pop_front()); void'(exp_fy.pop_front()); end
          fcnt = -1;
        end else fcnt--;
      end
      @(negedge clk);
      cyc++;
    end
    check(rsp_valid == 1'b1, "R6 response arrives", rsp_valid, 1);
    for (int j = 0; j < 4; j++)
      check(rsp_texels[j*32 +: 32] == tex(x + j%2, y + j/2), "R2 texel",
            rsp_texels[j*32 +: 32], tex(x + j%2, y + j/2));
    check(cmp_count == CNT_W'(exp_cmp), "R3 R8 compare count", cmp_count, CNT_W'(exp_cmp));
    check(exp_fx.size() == 0, "R7 missing fill", exp_fx.size(), 0);
    if (misses == 0)
      check(cyc == ntile + 1, "R5 hit latency", cyc, ntile + 1);
    exp_fx.delete(); exp_fy.delete();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R6 single beat", rsp_valid, 0);
    check(req_ready == 1'b1, "R6 ready again", req_ready, 1);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin m_vld[b] = 0; m_tx[b] = 0; m_ty[b] = 0; end
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no rsp in reset", rsp_valid, 0);
    check(fill_req_valid == 1'b0, "R1 no fill in reset", fill_req_valid, 0);
    check(cmp_count == '0, "R1 count cleared", cmp_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 single tile, then R5 reuse
    do_req(5, 5, 1);
    do_req(5, 6, 0);
    do_req(6, 4, 0);
    // R3 horizontal, vertical, four-tile spans
    do_req(7, 5, 2);
    do_req(5, 7, 0);
    do_req(7, 7, 3);
    do_req(7, 6, 0);
    // R7 evictions skip buffers bound to this request
    do_req(11, 7, 1);
    do_req(7, 7, 0);
    // R9 stray fill with nothing outstanding
    @(negedge clk);
    fill_valid = 1'b1; fill_data = {16{32'hDEADBEEF}};
    @(negedge clk);
    fill_valid = 1'b0;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 stray fill ignored", {rsp_valid, req_ready}, 1);
    check(cmp_count == CNT_W'(exp_cmp), "R9 count unchanged", cmp_count, CNT_W'(exp_cmp));
    do_req(8, 6, 0);
    do_req(13, 8, 0);
    // Mixed stream over a small tile set
    begin
      int seed = 17;
      for (int n = 0; n < 120; n++) begin
        int x, y;
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        x = 4 + (seed >> 8) % 28;
        y = 4 + (seed >> 16) % 20;
        do_req(x, y, (seed >> 4) % 4);
      end
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule